// File: doc/BRIEF.md
# Two-Channel Pin Controller with Input-Change Interrupt

This block is a memory-mapped general-purpose I/O controller with one or two independent pin channels, each up to 32 bits wide. For every channel, software programs an output value register and a direction register. The block drives an output vector and an output-enable vector for each channel and samples that channel's input pins through a two-flop synchronizer.

A change detector per channel watches the synchronized input bits. When any bit currently configured as an input changes value, the detector sets that channel's sticky interrupt status bit. Each status bit is gated by its own channel enable, the gated bits are ORed together, and a global enable bit qualifies the result to form a single interrupt line. Software clears status bits by writing ones to them, so writing back a value it has just read acknowledges exactly the events it saw.

The host side is a single-cycle register bus. Writes take effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_pair_irq`

## Requirements
- R1: After reset, every direction bit is 1, so all output enables are 0. Output values are 0, and the status, channel-enable and global-enable registers are 0, so the interrupt line is low. The direction and output reset values are parameters.
- R2: A write to offset 0x0 (channel 1) or 0x8 (channel 2) sets that channel's output value, which appears on its output vector after the write edge. A write to offset 0x4 or 0xC sets the direction. A direction bit of 1 means input, and its output-enable bit is then 0; a direction bit of 0 means output, and its output-enable bit is then 1.
- R3: Reading offset 0x0 or 0x8 returns, bit by bit, the synchronized pin value where the direction bit is 1 and the output register value where it is 0. A pin change becomes visible in the read value after two clock edges.
- R4: A change on any input-direction bit of channel 1 sets status bit 0 at offset 0x120, and a change on channel 2 sets status bit 1. The bit sets on the third clock edge after the pin change and stays set until cleared.
- R5: A change on a pin whose direction bit is 0 does not set any status bit.
- R6: Writing to offset 0x120 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. If a change is detected in the same cycle as the clear of that bit, the bit stays set.
- R7: The interrupt output equals bit 31 of the global-enable register (offset 0x11C) ANDed with the OR over channels of (status bit AND channel-enable bit). The channel-enable register is at offset 0x128, with bit 0 for channel 1 and bit 1 for channel 2.
- R8: The global-enable register reads back only bit 31, and the channel-enable register reads back only bits 1:0. Addresses outside the seven mapped offsets read 0, and writes to them change no register.
- R9: Data and direction bits at or above the channel width read as 0 and are not stored.
- R10: When the second channel is disabled by parameter, its data and direction offsets read 0, its output and output-enable vectors stay 0, status bit 1 never sets, and channel-enable bit 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin0_in | input | W0 | Channel 1 input pins (asynchronous) |
| pin0_out | output | W0 | Channel 1 output values |
| pin0_oe | output | W0 | Channel 1 output enables (1 = drive) |
| pin1_in | input | W1 | Channel 2 input pins (asynchronous) |
| pin1_out | output | W1 | Channel 2 output values |
| pin1_oe | output | W1 | Channel 2 output enables (1 = drive) |
| irq | output | 1 | Interrupt request, active high |

## Verification
A corrupted output or direction register shows up at once on the output or output-enable vector after the write edge, and through the combinational data read in the same cycle. A fault in the synchronizer or the change detector shows up as a status bit that sets one cycle early, one cycle late, or not at all, so the bench samples both the second and the third edge after each pin toggle. A wrong clear or priority path leaves a status bit stuck or dropped, and because the interrupt line is combinational over status and enables, the bench sees that on the interrupt pin in the same cycle. Sweeps cover every data/direction pair on a narrow configuration and every combination of global enable, channel enables and pending status.

// File: rtl/gpio_pair_irq.sv
module gpio_pair_irq #(
  parameter int          W0       = 32,
  parameter int          W1       = 32,
  parameter bit          DUAL     = 1'b1,
  parameter logic [31:0] OUT0_RST = 32'h0,
  parameter logic [31:0] DIR0_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] OUT1_RST = 32'h0,
  parameter logic [31:0] DIR1_RST = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [8:0]    bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [W0-1:0] pin0_in,
  output logic [W0-1:0] pin0_out,
  output logic [W0-1:0] pin0_oe,
  input  logic [W1-1:0] pin1_in,
  output logic [W1-1:0] pin1_out,
  output logic [W1-1:0] pin1_oe,
  output logic          irq
);

  localparam logic [8:0] A_D0  = 9'h000;
  localparam logic [8:0] A_T0  = 9'h004;
  localparam logic [8:0] A_D1  = 9'h008;
  localparam logic [8:0] A_T1  = 9'h00C;
  localparam logic [8:0] A_GIE = 9'h11C;
  localparam logic [8:0] A_ISR = 9'h120;
  localparam logic [8:0] A_IER = 9'h128;

  logic [W0-1:0] out0, dir0, s0a, s0b, s0c;
  logic [W1-1:0] out1, dir1;
  logic [31:0]   rd0, rd1;
  logic          chg0, chg1;
  logic [1:0]    status, ien, clr;
  logic          gie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out0 <= OUT0_RST[W0-1:0];
      dir0 <= DIR0_RST[W0-1:0];
      s0a  <= '0;
      s0b  <= '0;
      s0c  <= '0;
    end else begin
      if (bus_we && bus_addr == A_D0) out0 <= bus_wdata[W0-1:0];
      if (bus_we && bus_addr == A_T0) dir0 <= bus_wdata[W0-1:0];
      s0a <= pin0_in;
      s0b <= s0a;
      s0c <= s0b;
    end
  end

  assign chg0     = |((s0b ^ s0c) & dir0);
  assign pin0_out = out0;
  assign pin0_oe  = ~dir0;
  assign rd0      = 32'((s0b & dir0) | (out0 & ~dir0));

  generate
    if (DUAL) begin : g_ch1
      logic [W1-1:0] s1a, s1b, s1c;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out1 <= OUT1_RST[W1-1:0];
          dir1 <= DIR1_RST[W1-1:0];
          s1a  <= '0;
          s1b  <= '0;
          s1c  <= '0;
        end else begin
          if (bus_we && bus_addr == A_D1) out1 <= bus_wdata[W1-1:0];
          if (bus_we && bus_addr == A_T1) dir1 <= bus_wdata[W1-1:0];
          s1a <= pin1_in;
          s1b <= s1a;
          s1c <= s1b;
        end
      end
      assign chg1     = |((s1b ^ s1c) & dir1);
      assign rd1      = 32'((s1b & dir1) | (out1 & ~dir1));
      assign pin1_out = out1;
      assign pin1_oe  = ~dir1;
    end else begin : g_no_ch1
      assign out1     = '0;
      assign dir1     = '1;
      assign chg1     = 1'b0;
      assign rd1      = 32'h0;
      assign pin1_out = '0;
      assign pin1_oe  = '0;

      assert_single_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !status[1] && !ien[1] && pin1_oe == '0);
    end
  endgenerate

  assign clr = (bus_we && bus_addr == A_ISR) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 2'b00;
      ien    <= 2'b00;
      gie    <= 1'b0;
    end else begin
      status <= (status & ~clr) | {chg1, chg0};
      if (bus_we && bus_addr == A_IER) ien <= bus_wdata[1:0] & {DUAL, 1'b1};
      if (bus_we && bus_addr == A_GIE) gie <= bus_wdata[31];
    end
  end

  assign irq = gie & |(status & ien);

  always_comb begin
    case (bus_addr)
      A_D0:    bus_rdata = rd0;
      A_T0:    bus_rdata = 32'(dir0);
      A_D1:    bus_rdata = rd1;
      A_T1:    bus_rdata = DUAL ? 32'(dir1) : 32'h0;
      A_GIE:   bus_rdata = {gie, 31'h0};
      A_ISR:   bus_rdata = {30'h0, status};
      A_IER:   bus_rdata = {30'h0, ien};
      default: bus_rdata = 32'h0;
    endcase
  end

  assert_status_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !(bus_we && bus_addr == A_ISR && bus_wdata[0])) |=> status[0]);

  assert_change_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chg0 |=> status[0]);

  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ISR && bus_wdata[0] && !chg0) |=> !status[0]);

  assert_gie_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_GIE && !bus_wdata[31]) |=> !irq);

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_T0) |=> (pin0_oe == ~$past(bus_wdata[W0-1:0])));

endmodule

// File: tb/sim_gpio_pair_irq.sv
module sim_gpio_pair_irq;
  localparam int W0 = 4;
  localparam int W1 = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] addr = 9'h0;
  logic we = 1'b0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata, rdata_b;
  logic [W0-1:0] pin0 = '0;
  logic [W1-1:0] pin1 = '0;
  logic [W0-1:0] p0out, p0oe, b0out, b0oe;
  logic [W1-1:0] p1out, p1oe, b1out, b1oe;
  logic irq, irq_b;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_pair_irq #(.W0(W0), .W1(W1), .DUAL(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin0_in(pin0), .pin0_out(p0out), .pin0_oe(p0oe),
    .pin1_in(pin1), .pin1_out(p1out), .pin1_oe(p1oe), .irq(irq));

  gpio_pair_irq #(.W0(W0), .W1(W1), .DUAL(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata_b), .pin0_in(pin0), .pin0_out(b0out), .pin0_oe(b0oe),
    .pin1_in(pin1), .pin1_out(b1out), .pin1_oe(b1oe), .irq(irq_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v, output logic [31:0] vb);
    addr = a;
    #1;
    v = rdata;
    vb = rdata_b;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v, vb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe0", 32'(p0oe), 0);
    chk("R1 oe1", 32'(p1oe), 0);
    chk("R1 out0", 32'(p0out), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(9'h004, v, vb); chk("R1 dir0", v, 32'hF);
    rd(9'h00C, v, vb); chk("R1 dir1", v, 32'h7);
    rd(9'h120, v, vb); chk("R1 status", v, 0);
    rd(9'h128, v, vb); chk("R1 ien", v, 0);
    rd(9'h11C, v, vb); chk("R1 gie", v, 0);

    // R2 R3 sweep channel 1
    pin0 = 4'b1010; pin1 = 3'b101;
    settle();
    wr(9'h120, 3);
    for (int d = 0; d < 16; d++) begin
      for (int t = 0; t < 16; t++) begin
        wr(9'h000, d); wr(9'h004, t);
        chk("R2 out0", 32'(p0out), d);
        chk("R2 oe0", 32'(p0oe), (~t) & 32'hF);
        rd(9'h000, v, vb);
        chk("R3 read0", v, (32'hA & t) | (d & ~t & 32'hF));
      end
    end
    // R2 R3 sweep channel 2
    for (int d = 0; d < 8; d++) begin
      for (int t = 0; t < 8; t++) begin
        wr(9'h008, d); wr(9'h00C, t);
        chk("R2 out1", 32'(p1out), d);
        chk("R2 oe1", 32'(p1oe), (~t) & 32'h7);
        rd(9'h008, v, vb);
        chk("R3 read1", v, (32'h5 & t) | (d & ~t & 32'h7));
      end
    end
    rd(9'h120, v, vb); chk("R5 no event from direction writes", v, 0);

    // R9 width clipping
    wr(9'h004, 0); wr(9'h000, 32'hFFFF_FFFF);
    rd(9'h000, v, vb); chk("R9 data width", v, 32'hF);
    wr(9'h004, 32'hFFFF_FFFF);
    rd(9'h004, v, vb); chk("R9 dir width", v, 32'hF);
    wr(9'h00C, 32'hFFFF_FFFF);
    rd(9'h00C, v, vb); chk("R9 dir1 width", v, 32'h7);

    // R4 change detect, latency, per bit
    wr(9'h120, 3);
    for (int b = 0; b < W0; b++) begin
      @(negedge clk); pin0[b] = ~pin0[b];
      @(negedge clk); @(negedge clk);
      rd(9'h120, v, vb); chk("R4 not yet at edge 2", v, 0);
      rd(9'h000, v, vb); chk("R3 latency", v, 32'(pin0));
      @(negedge clk);
      rd(9'h120, v, vb); chk("R4 ch1 status", v, 1);
      wr(9'h120, 1);
      rd(9'h120, v, vb); chk("R6 clear ch1", v, 0);
    end
    for (int b = 0; b < W1; b++) begin
      @(negedge clk); pin1[b] = ~pin1[b];
      settle();
      rd(9'h120, v, vb); chk("R4 ch2 status", v, 2);
      wr(9'h120, 2);
      rd(9'h120, v, vb); chk("R6 clear ch2", v, 0);
    end

    // R5 output-direction pins ignored
    wr(9'h004, 0); wr(9'h00C, 0);
    @(negedge clk); pin0 = ~pin0; pin1 = ~pin1;
    settle();
    rd(9'h120, v, vb); chk("R5 output pins no event", v, 0);
    wr(9'h004, 32'hF); wr(9'h00C, 32'h7);
    settle();
    rd(9'h120, v, vb); chk("R5 no event after turning to input", v, 0);

    // R6 selective clear and priority
    @(negedge clk); pin0[0] = ~pin0[0]; pin1[0] = ~pin1[0];
    settle();
    rd(9'h120, v, vb); chk("R4 both", v, 3);
    wr(9'h120, 1);
    rd(9'h120, v, vb); chk("R6 partial clear", v, 2);
    wr(9'h120, 0);
    rd(9'h120, v, vb); chk("R6 zero write keeps", v, 2);
    wr(9'h120, 2);
    rd(9'h120, v, vb); chk("R6 write-back clear", v, 0);
    @(negedge clk); pin0[1] = ~pin0[1];
    @(negedge clk);
    @(negedge clk);
    addr = 9'h120; wdata = 32'h1; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd(9'h120, v, vb); chk("R6 change wins over clear", v, 1);
    wr(9'h120, 1);
    rd(9'h120, v, vb); chk("R6 later clear", v, 0);

    // R7 interrupt sweep
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 4; e++) begin
        for (int s = 0; s < 4; s++) begin
          wr(9'h11C, 0);
          wr(9'h120, 3);
          wr(9'h128, e);
          @(negedge clk);
          if (s[0]) pin0[2] = ~pin0[2];
          if (s[1]) pin1[2] = ~pin1[2];
          settle();
          wr(9'h11C, g ? 32'h8000_0000 : 32'h0);
          chk("R7 irq", 32'(irq), 32'(g != 0 && (s & e) != 0));
        end
      end
    end
    wr(9'h11C, 0);
    chk("R7 irq off after gie clear", 32'(irq), 0);

    // R8 readback masks and unmapped space
    wr(9'h120, 3);
    wr(9'h11C, 32'hFFFF_FFFF);
    rd(9'h11C, v, vb); chk("R8 gie readback", v, 32'h8000_0000);
    wr(9'h128, 32'hFFFF_FFFF);
    rd(9'h128, v, vb); chk("R8 ien readback", v, 3);
    wr(9'h128, 0); wr(9'h11C, 0);
    wr(9'h004, 32'h3); wr(9'h000, 32'h4);
    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h124, 32'hFFFF_FFFF);
    wr(9'h104, 32'hFFFF_FFFF);
    rd(9'h010, v, vb); chk("R8 unmapped read", v, 0);
    rd(9'h124, v, vb); chk("R8 unmapped read 124", v, 0);
    rd(9'h004, v, vb); chk("R8 dir untouched", v, 3);
    chk("R8 out untouched", 32'(p0out), 4);
    rd(9'h128, v, vb); chk("R8 ien untouched", v, 0);

    // R10 single-channel instance
    wr(9'h008, 32'h7); wr(9'h00C, 32'h0);
    rd(9'h008, v, vb); chk("R10 data1 reads 0", vb, 0);
    rd(9'h00C, v, vb); chk("R10 dir1 reads 0", vb, 0);
    chk("R10 oe1 zero", 32'(b1oe), 0);
    chk("R10 out1 zero", 32'(b1out), 0);
    wr(9'h00C, 32'h7);
    wr(9'h120, 3);
    @(negedge clk); pin1 = ~pin1;
    settle();
    rd(9'h120, v, vb); chk("R10 status1 stays 0", vb, 0);
    chk("R4 dual instance still sees ch2", v, 2);
    wr(9'h128, 3);
    rd(9'h128, v, vb); chk("R10 ien bit1 reads 0", vb, 1);

    finish_run();
  end
endmodule